// File: doc/BRIEF.md
# Audio Sample Playout Stage

This block turns buffered 16-bit sample words into a steady stream of 8-bit signed samples for a left and a right DAC. A fetch controller pushes words into a four-word buffer inside the block and watches a not-full flag to decide when to fetch more. The block pops words from that buffer at a programmable sample rate and loads the two output sample registers.

The sample rate comes from the system clock. A fixed prescaler divides the clock by 160 to form a base tick. A 2-bit rate select then keeps every first, second, fourth or eighth base tick. With a clock near 8 MHz this gives rates of about 50, 25, 12.5 and 6.25 kHz. In stereo mode each sample period uses one word: one byte goes to each channel. In mono mode each period plays one byte on both channels, so a word lasts for two periods. If the buffer is empty when a sample period ends, both outputs keep their last values. Clearing the enable input resets the rate counters, so the first sample after enabling comes one full period later.

Top module: `audio_playout`

## Requirements
- R1: After reset both sample outputs are 0 and the not-full flag is 1, because the buffer is empty.
- R2: With rate select 0, the outputs first change on the 160th rising clock edge at which enable is high, and then on every 160th edge after that.
- R3: Rate select values 1, 2 and 3 stretch the sample period to 320, 640 and 1280 clock edges. The first sample after enabling arrives at that count.
- R4: In stereo mode (stereo input 1) each sample period pops one word. Bits 15:8 go to the left output and bits 7:0 go to the right output.
- R5: In mono mode (stereo input 0) the first period after a word reaches the head of the buffer drives bits 15:8 to both outputs. The next period drives bits 7:0 to both outputs and pops the word.
- R6: When the buffer is empty at the end of a sample period, both outputs keep their previous values and nothing is popped.
- R7: While enable is low, no sample period ends and the outputs hold. Each period counter returns to zero, and the mono byte phase returns to the high byte. Buffered words are kept.
- R8: The buffer holds 4 words in arrival order, and the not-full flag is 0 while it holds 4. A push while the buffer is full is dropped.
- R9: A push and a pop in the same cycle both take effect: the popped word is played and the pushed word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| play_en | input | 1 | Playback enable; low clears the rate counters and the mono phase |
| stereo | input | 1 | 1 selects stereo unpacking, 0 selects mono |
| rate_sel | input | 2 | Rate select: the base tick is divided by 2 to the power rate_sel |
| push | input | 1 | Push strobe from the fetch controller |
| push_word | input | 16 | Sample word to push |
| fifo_not_full | output | 1 | High while the buffer can accept a word |
| left_sample | output | 8 | Left channel sample register |
| right_sample | output | 8 | Right channel sample register |

## Verification
A push from the fetch side and a pop at the end of a sample period can happen on the same clock edge. The bench provokes this by holding one word and counting edges, so that a push lands exactly on the edge where a period ends. It does this with a non-empty buffer and with an empty buffer. The first case must play the old word and keep the new one. The second must hold the outputs and keep the new word for the next period. A behavioural queue model in the bench is compared with the outputs and the not-full flag on every clock.

// File: rtl/audio_play_pkg.sv
package audio_play_pkg;
  // Rate select encoding: base tick divided by 2**code.
  typedef enum logic [1:0] {
    RATE_DIV1 = 2'd0,
    RATE_DIV2 = 2'd1,
    RATE_DIV4 = 2'd2,
    RATE_DIV8 = 2'd3
  } rate_sel_e;

  localparam int unsigned SAMPLE_W = 8;
  localparam int unsigned WORD_W   = 2 * SAMPLE_W;
endpackage

// File: rtl/audio_rate_gen.sv
module audio_rate_gen #(
  parameter int unsigned CLK_DIV   = 160,
  parameter int unsigned RATE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [RATE_BITS-1:0] rate_sel,
  output logic                 strobe
);
  localparam int unsigned PC_W = $clog2(CLK_DIV);
  localparam int unsigned TC_W = (1 << RATE_BITS) - 1;

  logic [PC_W-1:0] pre_q, pre_d;
  logic [TC_W-1:0] div_q, div_d;
  logic [TC_W-1:0] div_lim;
  logic            base_tick, div_last;

  always_comb begin
    div_lim   = TC_W'((1 << rate_sel) - 1);
    base_tick = (pre_q == PC_W'(CLK_DIV - 1));
    div_last  = (div_q >= div_lim);
    strobe    = en & base_tick & div_last;
    pre_d     = pre_q;
    div_d     = div_q;
    if (!en) begin
      pre_d = '0;
      div_d = '0;
    end else if (base_tick) begin
      pre_d = '0;
      div_d = div_last ? '0 : div_q + TC_W'(1);
    end else begin
      pre_d = pre_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/audio_word_fifo.sv
module audio_word_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       not_full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  always_comb begin
    empty    = (cnt_q == '0);
    not_full = (cnt_q != CW'(DEPTH));
    push_ok  = push & not_full;
    pop_ok   = pop & ~empty;
    dout     = mem[rd_q];
    fill     = cnt_q;
    rd_d     = rd_q;
    wr_d     = wr_q;
    cnt_d    = cnt_q;
    if (pop_ok)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    if (push_ok) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_q == AW'(i))) mem[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/audio_chan_unpack.sv
module audio_chan_unpack #(
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stereo,
  input  logic          strobe,
  input  logic          empty,
  input  logic [2*SW-1:0] word,
  output logic          pop,
  output logic [SW-1:0] left,
  output logic [SW-1:0] right
);
  logic          half_q, half_d, take;
  logic [SW-1:0] l_d, r_d;
  logic [SW-1:0] hi_b, lo_b;

  always_comb begin
    hi_b = word[2*SW-1:SW];
    lo_b = word[SW-1:0];
    take = strobe & ~empty;
    if (stereo) begin
      pop    = take;
      l_d    = hi_b;
      r_d    = lo_b;
      half_d = 1'b0;
    end else begin
      pop    = take & half_q;
      l_d    = half_q ? lo_b : hi_b;
      r_d    = l_d;
      half_d = take ? ~half_q : half_q;
    end
    if (!en) half_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      left   <= '0;
      right  <= '0;
    end else begin
      half_q <= half_d;
      if (take) begin
        left  <= l_d;
        right <= r_d;
      end
    end
  end
endmodule

// File: rtl/audio_playout.sv
module audio_playout
  import audio_play_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 160,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                play_en,
  input  logic                stereo,
  input  logic [1:0]          rate_sel,
  input  logic                push,
  input  logic [WORD_W-1:0]   push_word,
  output logic                fifo_not_full,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              smp_stb, fifo_pop, fifo_empty;
  logic [WORD_W-1:0] head_word;
  logic [CW-1:0]     fifo_fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  audio_rate_gen #(.CLK_DIV(CLK_DIV), .RATE_BITS(2)) u_rate (
    .clk(clk), .rst_n(rst_int_n), .en(play_en), .rate_sel(rate_sel),
    .strobe(smp_stb)
  );

  audio_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .push(push), .din(push_word),
    .pop(fifo_pop), .dout(head_word), .empty(fifo_empty),
    .not_full(fifo_not_full), .fill(fifo_fill)
  );

  audio_chan_unpack #(.SW(SAMPLE_W)) u_unpack (
    .clk(clk), .rst_n(rst_int_n), .en(play_en), .stereo(stereo),
    .strobe(smp_stb), .empty(fifo_empty), .word(head_word),
    .pop(fifo_pop), .left(left_sample), .right(right_sample)
  );
endmodule

// File: rtl/audio_playout_chk.sv
module audio_playout_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       play_en,
  input logic                       stereo,
  input logic                       strobe,
  input logic                       empty,
  input logic                       pop,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic [7:0]                 left_sample,
  input logic [7:0]                 right_sample
);
  p_no_strobe_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |-> !strobe);

  p_hold_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && empty) |=> ($stable(left_sample) && $stable(right_sample)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  p_stereo_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !empty && stereo) |-> pop);

  p_stable_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(left_sample) && $stable(right_sample)));

  p_mono_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !empty && !stereo) |=> (left_sample == right_sample));

  p_pop_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> strobe);
endmodule

bind audio_playout audio_playout_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .play_en(play_en), .stereo(stereo),
  .strobe(smp_stb), .empty(fifo_empty), .pop(fifo_pop), .fill(fifo_fill),
  .left_sample(left_sample), .right_sample(right_sample)
);

// File: tb/audio_playout_tb.sv
`timescale 1ns/1ps
module audio_playout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        play_en = 1'b0;
  logic        stereo = 1'b1;
  logic [1:0]  rate_sel = 2'd0;
  logic        push = 1'b0;
  logic [15:0] push_word = 16'h0;
  logic        fifo_not_full;
  logic [7:0]  left_sample, right_sample;

  int checks = 0, fails = 0;
  bit done = 0;
  string req_tag = "R1";

  always #2 clk = ~clk;

  audio_playout u_dut (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .stereo(stereo),
    .rate_sel(rate_sel), .push(push), .push_word(push_word),
    .fifo_not_full(fifo_not_full), .left_sample(left_sample),
    .right_sample(right_sample)
  );

  // Behavioural reference model
  logic [15:0] q[$];
  int   m_base, m_sub;
  bit   m_half;
  logic [7:0] m_l, m_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_base = 0; m_sub = 0; m_half = 0; m_l = 0; m_r = 0;
    end else begin
      bit stb, did_pop;
      int sz;
      sz = q.size();
      stb = 0; did_pop = 0;
      if (!play_en) begin
        m_base = 0; m_sub = 0; m_half = 0;
      end else begin
        if (m_base == 159) begin
          m_base = 0;
          if (m_sub >= (1 << rate_sel) - 1) begin stb = 1; m_sub = 0; end
          else m_sub++;
        end else m_base++;
      end
      if (stb && sz > 0) begin
        if (stereo) begin
          m_l = q[0][15:8]; m_r = q[0][7:0]; did_pop = 1; m_half = 0;
        end else begin
          m_l = m_half ? q[0][7:0] : q[0][15:8]; m_r = m_l;
          did_pop = m_half; m_half = !m_half;
        end
      end
      if (stereo) m_half = 0;
      if (did_pop) void'(q.pop_front());
      if (push && sz < 4) q.push_back(push_word);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (left_sample !== m_l || right_sample !== m_r ||
          fifo_not_full !== (q.size() < 4)) begin
        fails++;
        $display("FAIL %s model: L=%h R=%h nf=%b expected L=%h R=%h nf=%b",
                 req_tag, left_sample, right_sample, fifo_not_full,
                 m_l, m_r, (q.size() < 4));
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic push_w(logic [15:0] w);
    push = 1'b1; push_word = w; step(1); push = 1'b0;
  endtask

  task automatic chk(string r, logic [7:0] l, logic [7:0] rr, logic [7:0] el, logic [7:0] er);
    checks++;
    if (l !== el || rr !== er) begin
      fails++;
      $display("FAIL %s L=%h R=%h expected L=%h R=%h", r, l, rr, el, er);
    end
  endtask

  task automatic chk_bit(string r, logic a, logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s flag=%b expected %b", r, a, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1'b1; step(4);
    // R1: reset state
    req_tag = "R1";
    chk("R1", left_sample, right_sample, 8'h00, 8'h00);
    chk_bit("R1", fifo_not_full, 1'b1);

    // R2/R4: stereo at base rate, R6 empty hold
    req_tag = "R4";
    push_w(16'h1234); push_w(16'h5678); push_w(16'hABCD);
    play_en = 1'b1;
    step(159); chk("R2", left_sample, right_sample, 8'h00, 8'h00);
    step(1);   chk("R2", left_sample, right_sample, 8'h12, 8'h34);
    step(160); chk("R4", left_sample, right_sample, 8'h56, 8'h78);
    step(160); chk("R4", left_sample, right_sample, 8'hAB, 8'hCD);
    req_tag = "R6";
    step(480); chk("R6", left_sample, right_sample, 8'hAB, 8'hCD);
    play_en = 1'b0; step(2);

    // R3: slower rates
    req_tag = "R3";
    rate_sel = 2'd2; push_w(16'h1122); play_en = 1'b1;
    step(639); chk("R3", left_sample, right_sample, 8'hAB, 8'hCD);
    step(1);   chk("R3", left_sample, right_sample, 8'h11, 8'h22);
    play_en = 1'b0; rate_sel = 2'd3; push_w(16'h3344); play_en = 1'b1;
    step(1279); chk("R3", left_sample, right_sample, 8'h11, 8'h22);
    step(1);    chk("R3", left_sample, right_sample, 8'h33, 8'h44);
    play_en = 1'b0; rate_sel = 2'd1; push_w(16'h5566); play_en = 1'b1;
    step(320); chk("R3", left_sample, right_sample, 8'h55, 8'h66);
    play_en = 1'b0; rate_sel = 2'd0; step(2);

    // R5: mono
    req_tag = "R5";
    stereo = 1'b0; push_w(16'h8090); push_w(16'hA0B0); play_en = 1'b1;
    step(160); chk("R5", left_sample, right_sample, 8'h80, 8'h80);
    step(160); chk("R5", left_sample, right_sample, 8'h90, 8'h90);
    step(160); chk("R5", left_sample, right_sample, 8'hA0, 8'hA0);
    step(160); chk("R5", left_sample, right_sample, 8'hB0, 8'hB0);
    play_en = 1'b0; step(2);

    // R7: disable resets counters and mono phase
    req_tag = "R7";
    push_w(16'hC0D0); play_en = 1'b1;
    step(160); chk("R7", left_sample, right_sample, 8'hC0, 8'hC0);
    play_en = 1'b0; step(50);
    chk("R7", left_sample, right_sample, 8'hC0, 8'hC0);
    play_en = 1'b1; step(100); play_en = 1'b0; step(10);
    chk("R7", left_sample, right_sample, 8'hC0, 8'hC0);
    play_en = 1'b1;
    step(159); chk("R7", left_sample, right_sample, 8'hC0, 8'hC0);
    step(1);   chk("R7", left_sample, right_sample, 8'hC0, 8'hC0);
    step(160); chk("R7", left_sample, right_sample, 8'hD0, 8'hD0);
    play_en = 1'b0; stereo = 1'b1; step(2);

    // R8: depth and overflow drop
    req_tag = "R8";
    push_w(16'h0102); push_w(16'h0304); push_w(16'h0506);
    chk_bit("R8", fifo_not_full, 1'b1);
    push_w(16'h0708);
    chk_bit("R8", fifo_not_full, 1'b0);
    push_w(16'h090A);
    play_en = 1'b1;
    step(160); chk("R8", left_sample, right_sample, 8'h01, 8'h02);
    chk_bit("R8", fifo_not_full, 1'b1);
    step(480); chk("R8", left_sample, right_sample, 8'h07, 8'h08);
    step(160); chk("R8", left_sample, right_sample, 8'h07, 8'h08);
    play_en = 1'b0; step(2);

    // R9: push and pop on the same edge
    req_tag = "R9";
    push_w(16'h2122); play_en = 1'b1;
    step(159); push_w(16'h2324);
    chk("R9", left_sample, right_sample, 8'h21, 8'h22);
    step(160); chk("R9", left_sample, right_sample, 8'h23, 8'h24);
    step(159); push_w(16'h2526);     // empty at this strobe: hold, keep word
    chk("R9", left_sample, right_sample, 8'h23, 8'h24);
    step(160); chk("R9", left_sample, right_sample, 8'h25, 8'h26);
    play_en = 1'b0; step(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule